// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block keeps a 64-bit nanosecond time value and produces up to three periodic pulse trains from it. Any one of these trains can serve as a once-per-second marker. The time value advances by a programmable integer tick on every clock. Software can overwrite it with a 64-bit value, written as two 32-bit halves.

Each channel holds its output idle until a 64-bit alarm comparator fires. The first pulse of a train is therefore aligned to a chosen instant, such as a whole second. After that first pulse, the channel issues a new pulse each time the time value has moved on by the channel's interval plus one tick. Pulse width is counted in ticks of a prescaled output clock.

A time step does not move a running train. To realign a train, software disables the channel, re-enables it and programs a new alarm. Every pulse start sets a sticky event flag, and so does every alarm match. A mask gates these flags onto one interrupt line. All registers sit behind a 32-bit word-indexed write/read port with a combinational read.

Top module: `pps_pulse_gen`

Register indices (word): 0 tick period, 1 time low, 2 time high, 3 alarm low, 4 alarm high, 5 channel control, 6 events, 7 event mask, 8 output prescaler, 12+i interval of channel i.

## Requirements
- R1: Out of reset, the time value is 0, the tick is 8 and the prescaler is 2. Both alarm halves and all intervals read all ones. Control reads 0x00808080, events and mask read 0, and every output and the interrupt are low.
- R2: Each clock the time value grows by the tick. A write to index 1 is staged. A following write to index 2 loads {high, staged low}, and the time value equals that value in the next cycle.
- R3: The alarm ({index 4, staged index 3}) matches in the first cycle the time value is greater than or equal to it. A match sets event bit 16 and returns the alarm to all ones, which never matches.
- R4: An enabled channel with its free-start bit clear starts on the alarm match. Its output turns active in the next cycle, when the time value reads E + tick, where E is the first value that reached the alarm.
- R5: A running channel starts a new pulse every interval + tick nanoseconds (interval a multiple of the tick), i.e. every (interval/tick + 1) clocks.
- R6: A pulse stays active for max(width,1) × max(prescaler,1) clocks. Width is bits 4:0 of the channel's control byte.
- R7: Control byte i sits at bits 8i+7..8i. Bit 6 of the byte inverts the output, so that an inverted channel idles high and pulses low.
- R8: While bit 7 (disable) of a channel's byte is set, its output stays at the idle level and an alarm match is ignored. Once the bit is cleared, the channel stays idle until a later alarm match.
- R9: With bit 5 (free-start) set, an enabled channel needs no alarm. Its first pulse goes active one cycle after the control write takes effect.
- R10: Writing the time value leaves a running channel's clock-count phase unchanged. Disabling the channel, enabling it and writing a fresh alarm realigns its pulses to that alarm.
- R11: Channel i's pulse start sets event bit 7−i. Writing 1 to an event bit clears it. A flag set and a clear of the same bit in the same cycle leave the flag set.
- R12: The interrupt is high exactly when some event bit and the same mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| now_ns | output | 64 | Current time value in nanoseconds |
| pulse_out | output | 3 | Pulse outputs, one per channel |
| irq | output | 1 | Masked event interrupt |

## Verification
The two functions that can land in one cycle are a channel's pulse start and a software write-one-to-clear of that same channel's event flag. The bench observes a pulse on channel 0 and counts the known period in clocks from it. It then issues the clear so that the write is sampled on the very edge that starts the next pulse. The flag must read set afterwards, and the spacing of the pulses must be unchanged. A second clear, issued away from any pulse start, must bring the flag to zero.

// File: rtl/pps_gen_pkg.sv
package pps_gen_pkg;

    localparam int WIDTH_W = 5;
    localparam int PRESC_W = 8;
    localparam int LEN_W   = WIDTH_W + PRESC_W;

    // word indices of the register port
    localparam int REG_TICK    = 0;
    localparam int REG_TIME_LO = 1;
    localparam int REG_TIME_HI = 2;
    localparam int REG_ALM_LO  = 3;
    localparam int REG_ALM_HI  = 4;
    localparam int REG_CTRL    = 5;
    localparam int REG_EVENT   = 6;
    localparam int REG_MASK    = 7;
    localparam int REG_PRESC   = 8;
    localparam int REG_IVL0    = 12;

    localparam int ALARM_EVT_BIT = 16;

    typedef enum logic {
        CH_WAIT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // one control byte per channel; field order is decoded by hardware
    typedef struct packed {
        logic               dis;
        logic               inv;
        logic               free_start;
        logic [WIDTH_W-1:0] width;
    } ch_ctrl_t;

    localparam ch_ctrl_t CTRL_RST = '{dis: 1'b1, inv: 1'b0, free_start: 1'b0, width: '0};

    function automatic int evt_bit(input int ch);
        return 7 - ch;
    endfunction

    function automatic logic [LEN_W-1:0] pulse_len(input logic [WIDTH_W-1:0] w,
                                                   input logic [PRESC_W-1:0] p);
        logic [WIDTH_W-1:0] w_eff;
        logic [PRESC_W-1:0] p_eff;
        w_eff = (w == '0) ? WIDTH_W'(1) : w;
        p_eff = (p == '0) ? PRESC_W'(1) : p;
        return LEN_W'(w_eff) * LEN_W'(p_eff);
    endfunction

endpackage

// File: rtl/pps_timebase.sv
module pps_timebase
    import pps_gen_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] tick,
    input  logic              time_lo_we,
    input  logic              time_hi_we,
    input  logic              alarm_lo_we,
    input  logic              alarm_hi_we,
    input  logic [31:0]       wdata,
    output logic [63:0]       now,
    output logic [63:0]       alarm,
    output logic              alarm_hit
);

    logic [31:0] time_stage;
    logic [31:0] alarm_stage;
    logic        alarm_armed;

    assign alarm_armed = (alarm != '1);
    assign alarm_hit   = alarm_armed && (now >= alarm);

    always_ff @(posedge clk) begin
        if (rst) begin
            now         <= '0;
            alarm       <= '1;
            time_stage  <= '0;
            alarm_stage <= '0;
        end else begin
            if (time_lo_we) begin
                time_stage <= wdata;
            end
            if (time_hi_we) begin
                now <= {wdata, time_stage};
            end else begin
                now <= now + 64'(tick);
            end

            if (alarm_lo_we) begin
                alarm_stage <= wdata;
            end
            if (alarm_hi_we) begin
                alarm <= {wdata, alarm_stage};
            end else if (alarm_hit) begin
                alarm <= '1;
            end
        end
    end

endmodule

// File: rtl/pps_channel.sv
module pps_channel
    import pps_gen_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              free_start,
    input  logic              alarm_hit,
    input  logic [TICK_W-1:0] tick,
    input  logic [31:0]       interval,
    input  logic [LEN_W-1:0]  len,
    output logic              fire,
    output logic              active
);

    ch_state_e        state;
    logic [31:0]      remain;
    logic [LEN_W-1:0] act_cnt;

    always_comb begin
        fire = 1'b0;
        if (en) begin
            unique case (state)
                CH_WAIT: fire = free_start || alarm_hit;
                CH_RUN:  fire = (remain < 32'(tick));
                default: fire = 1'b0;
            endcase
        end
    end

    assign active = (act_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CH_WAIT;
            remain  <= '0;
            act_cnt <= '0;
        end else if (!en) begin
            state   <= CH_WAIT;
            act_cnt <= '0;
        end else if (fire) begin
            state   <= CH_RUN;
            remain  <= interval;
            act_cnt <= len;
        end else begin
            if (state == CH_RUN) begin
                remain <= remain - 32'(tick);
            end
            if (act_cnt != '0) begin
                act_cnt <= act_cnt - LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/pps_event.sv
module pps_event
    import pps_gen_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] fire,
    input  logic            alarm_hit,
    input  logic            evt_we,
    input  logic            mask_we,
    input  logic [31:0]     wdata,
    output logic [31:0]     evt_flags,
    output logic [31:0]     mask_q,
    output logic            irq
);

    logic [N_CH-1:0] ch_evt;
    logic            alm_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_evt  <= '0;
            alm_evt <= 1'b0;
            mask_q  <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                // a set in the same cycle overrides the clear
                ch_evt[i] <= (ch_evt[i] && !(evt_we && wdata[evt_bit(i)])) || fire[i];
            end
            alm_evt <= (alm_evt && !(evt_we && wdata[ALARM_EVT_BIT])) || alarm_hit;
            if (mask_we) begin
                mask_q <= wdata;
            end
        end
    end

    always_comb begin
        evt_flags = '0;
        for (int i = 0; i < N_CH; i++) begin
            evt_flags[evt_bit(i)] = ch_evt[i];
        end
        evt_flags[ALARM_EVT_BIT] = alm_evt;
    end

    assign irq = |(evt_flags & mask_q);

endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen
    import pps_gen_pkg::*;
#(
    parameter int N_CH      = 3,
    parameter int TICK_W    = 8,
    parameter int IDX_W     = 4,
    parameter int TICK_RST  = 8,
    parameter int PRESC_RST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [63:0]      now_ns,
    output logic [N_CH-1:0]  pulse_out,
    output logic             irq
);

    localparam int CTRL_BYTES = 4;

    logic [TICK_W-1:0]  tick_q;
    logic [PRESC_W-1:0] presc_q;
    ch_ctrl_t           ctrl_q [N_CH];
    logic [31:0]        ivl_q  [N_CH];

    logic [63:0]     alarm_q;
    logic            alarm_hit;
    logic [N_CH-1:0] fire_vec;
    logic [N_CH-1:0] active_vec;
    logic [N_CH-1:0] dis_vec;
    logic [N_CH-1:0] inv_vec;
    logic [31:0]     evt_flags;
    logic [31:0]     mask_q;

    logic we_tick, we_time_lo, we_time_hi, we_alm_lo, we_alm_hi;
    logic we_ctrl, we_evt, we_mask, we_presc;

    assign we_tick    = reg_we && (reg_idx == IDX_W'(REG_TICK));
    assign we_time_lo = reg_we && (reg_idx == IDX_W'(REG_TIME_LO));
    assign we_time_hi = reg_we && (reg_idx == IDX_W'(REG_TIME_HI));
    assign we_alm_lo  = reg_we && (reg_idx == IDX_W'(REG_ALM_LO));
    assign we_alm_hi  = reg_we && (reg_idx == IDX_W'(REG_ALM_HI));
    assign we_ctrl    = reg_we && (reg_idx == IDX_W'(REG_CTRL));
    assign we_evt     = reg_we && (reg_idx == IDX_W'(REG_EVENT));
    assign we_mask    = reg_we && (reg_idx == IDX_W'(REG_MASK));
    assign we_presc   = reg_we && (reg_idx == IDX_W'(REG_PRESC));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= TICK_W'(TICK_RST);
            presc_q <= PRESC_W'(PRESC_RST);
        end else begin
            if (we_tick) begin
                tick_q <= reg_wdata[TICK_W-1:0];
            end
            if (we_presc) begin
                presc_q <= reg_wdata[PRESC_W-1:0];
            end
        end
    end

    pps_timebase #(
        .TICK_W (TICK_W)
    ) u_timebase (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_q),
        .time_lo_we  (we_time_lo),
        .time_hi_we  (we_time_hi),
        .alarm_lo_we (we_alm_lo),
        .alarm_hi_we (we_alm_hi),
        .wdata       (reg_wdata),
        .now         (now_ns),
        .alarm       (alarm_q),
        .alarm_hit   (alarm_hit)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic we_ivl;
        assign we_ivl = reg_we && (reg_idx == IDX_W'(REG_IVL0 + i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[i] <= CTRL_RST;
                ivl_q[i]  <= '1;
            end else begin
                if (we_ctrl) begin
                    ctrl_q[i] <= ch_ctrl_t'(reg_wdata[8*i +: 8]);
                end
                if (we_ivl) begin
                    ivl_q[i] <= reg_wdata;
                end
            end
        end

        pps_channel #(
            .TICK_W (TICK_W)
        ) u_channel (
            .clk        (clk),
            .rst        (rst),
            .en         (!ctrl_q[i].dis),
            .free_start (ctrl_q[i].free_start),
            .alarm_hit  (alarm_hit),
            .tick       (tick_q),
            .interval   (ivl_q[i]),
            .len        (pulse_len(ctrl_q[i].width, presc_q)),
            .fire       (fire_vec[i]),
            .active     (active_vec[i])
        );

        assign dis_vec[i]   = ctrl_q[i].dis;
        assign inv_vec[i]   = ctrl_q[i].inv;
        assign pulse_out[i] = active_vec[i] ^ ctrl_q[i].inv;
    end

    pps_event #(
        .N_CH (N_CH)
    ) u_event (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire_vec),
        .alarm_hit (alarm_hit),
        .evt_we    (we_evt),
        .mask_we   (we_mask),
        .wdata     (reg_wdata),
        .evt_flags (evt_flags),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (int'(reg_idx))
            REG_TICK:    reg_rdata = 32'(tick_q);
            REG_TIME_LO: reg_rdata = now_ns[31:0];
            REG_TIME_HI: reg_rdata = now_ns[63:32];
            REG_ALM_LO:  reg_rdata = alarm_q[31:0];
            REG_ALM_HI:  reg_rdata = alarm_q[63:32];
            REG_CTRL: begin
                for (int i = 0; i < N_CH && i < CTRL_BYTES; i++) begin
                    reg_rdata[8*i +: 8] = ctrl_q[i];
                end
            end
            REG_EVENT:   reg_rdata = evt_flags;
            REG_MASK:    reg_rdata = mask_q;
            REG_PRESC:   reg_rdata = 32'(presc_q);
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (int'(reg_idx) == REG_IVL0 + i) begin
                        reg_rdata = ivl_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/pps_pulse_gen_chk.sv
module pps_pulse_gen_chk
    import pps_gen_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int TICK_W = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [31:0]       reg_wdata,
    input logic [63:0]       now_ns,
    input logic [TICK_W-1:0] tick_q,
    input logic [63:0]       alarm_q,
    input logic              alarm_hit,
    input logic [N_CH-1:0]   fire_vec,
    input logic [N_CH-1:0]   dis_vec,
    input logic [N_CH-1:0]   inv_vec,
    input logic [31:0]       evt_flags,
    input logic [N_CH-1:0]   pulse_out
);

    logic time_wr, alarm_wr, evt_wr;
    assign time_wr  = reg_we && (reg_idx == IDX_W'(REG_TIME_HI));
    assign alarm_wr = reg_we && (reg_idx == IDX_W'(REG_ALM_HI));
    assign evt_wr   = reg_we && (reg_idx == IDX_W'(REG_EVENT));

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
        !time_wr |=> (now_ns == $past(now_ns) + 64'($past(tick_q))))
        else $error("time did not advance by tick"); // R2

    AST_ALARM_IDLES: assert property (@(posedge clk) disable iff (rst)
        (alarm_hit && !alarm_wr) |=> (alarm_q == '1))
        else $error("alarm not returned to idle"); // R3

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
            (dis_vec[i] && $past(dis_vec[i])) |-> (pulse_out[i] == inv_vec[i]))
            else $error("disabled channel not idle"); // R8

        AST_FIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
            fire_vec[i] |=> evt_flags[evt_bit(i)])
            else $error("pulse start did not flag"); // R11

        AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (evt_flags[evt_bit(i)] && !(evt_wr && reg_wdata[evt_bit(i)])) |=> evt_flags[evt_bit(i)])
            else $error("event flag dropped without clear"); // R11
    end

endmodule

bind pps_pulse_gen pps_pulse_gen_chk #(
    .N_CH   (N_CH),
    .TICK_W (TICK_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .now_ns    (now_ns),
    .tick_q    (tick_q),
    .alarm_q   (alarm_q),
    .alarm_hit (alarm_hit),
    .fire_vec  (fire_vec),
    .dis_vec   (dis_vec),
    .inv_vec   (inv_vec),
    .evt_flags (evt_flags),
    .pulse_out (pulse_out)
);

// File: tb/pps_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module pps_pulse_gen_tb_top;
    import pps_gen_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] now_ns;
    logic [2:0]  pulse_out;
    logic        irq;

    always #2.5 clk = ~clk;

    pps_pulse_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .now_ns    (now_ns),
        .pulse_out (pulse_out),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // pulse monitor
    longint unsigned cyc = 0;
    int              rises [3] = '{0, 0, 0};
    longint unsigned rise_t [3], prev_rt [3], rise_c [3], prev_rc [3];
    int              wcnt [3] = '{0, 0, 0};
    int              last_w [3] = '{0, 0, 0};
    logic [2:0]      prev_out = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < 3; i++) begin
            if (pulse_out[i] && !prev_out[i]) begin
                rises[i]++;
                prev_rt[i] = rise_t[i];
                rise_t[i]  = now_ns;
                prev_rc[i] = rise_c[i];
                rise_c[i]  = cyc;
                wcnt[i]    = 1;
            end else if (pulse_out[i]) begin
                wcnt[i]++;
            end else if (prev_out[i]) begin
                last_w[i] = wcnt[i];
            end
            prev_out[i] = pulse_out[i];
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        report();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_idx   = 4'(idx);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = 4'(idx);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_rises(input int ch, input int n);
        int target;
        target = rises[ch] + n;
        while (rises[ch] < target) begin
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int exp_len(input int w, input int p);
        return ((w == 0) ? 1 : w) * ((p == 0) ? 1 : p);
    endfunction

    function automatic logic [31:0] ctrl_byte(input bit dis, input bit inv,
                                              input bit fs, input int w);
        return {24'b0, dis, inv, fs, 5'(w)};
    endfunction

    logic [31:0]     ctrl_m;
    logic [31:0]     d;
    logic [63:0]     t0, x, alm, pr;
    int              lows;
    int              seed;

    task automatic set_ctrl(input int ch, input logic [7:0] b);
        ctrl_m[8*ch +: 8] = b;
        wr(REG_CTRL, ctrl_m);
    endtask

    task automatic set_time(input logic [63:0] v);
        wr(REG_TIME_LO, v[31:0]);
        wr(REG_TIME_HI, v[63:32]);
    endtask

    task automatic set_alarm(input logic [63:0] v);
        wr(REG_ALM_LO, v[31:0]);
        wr(REG_ALM_HI, v[63:32]);
    endtask

    initial begin
        seed = $urandom(32'd4242);
        ctrl_m = 32'h0080_8080;
        repeat (3) @(negedge clk);
        // R1 reset state
        eq("R1", "now during reset", now_ns, 64'd0);
        eq("R1", "outputs during reset", 64'(pulse_out), 64'd0);
        eq("R1", "irq during reset", 64'(irq), 64'd0);
        rst = 1'b0;
        rd(REG_CTRL, d);  eq("R1", "control reset", 64'(d), 64'h0080_8080);
        rd(REG_ALM_LO, d); eq("R1", "alarm low reset", 64'(d), 64'hFFFF_FFFF);
        rd(REG_ALM_HI, d); eq("R1", "alarm high reset", 64'(d), 64'hFFFF_FFFF);
        rd(REG_IVL0 + 1, d); eq("R1", "interval reset", 64'(d), 64'hFFFF_FFFF);
        rd(REG_TICK, d);  eq("R1", "tick reset", 64'(d), 64'd8);
        rd(REG_PRESC, d); eq("R1", "prescaler reset", 64'(d), 64'd2);
        rd(REG_EVENT, d); eq("R1", "events reset", 64'(d), 64'd0);
        rd(REG_MASK, d);  eq("R1", "mask reset", 64'(d), 64'd0);

        // R2 time counter
        t0 = now_ns;
        @(negedge clk);
        eq("R2", "advance by tick", now_ns, t0 + 64'd8);
        set_time(64'h0000_0002_0000_0100);
        eq("R2", "loaded time", now_ns, 64'h0000_0002_0000_0100);
        @(negedge clk);
        eq("R2", "advance after load", now_ns, 64'h0000_0002_0000_0108);
        set_time(64'd0);

        // channel 0: alarm start at 5000, period 1000 ns, width 3
        wr(REG_IVL0 + 0, 32'd992);
        set_ctrl(0, ctrl_byte(0, 0, 0, 3));
        set_alarm(64'd5000);
        wait_rises(0, 1);
        eq("R4", "first rise time", rise_t[0], 64'd5008);
        rd(REG_ALM_LO, d); eq("R3", "alarm idle low", 64'(d), 64'hFFFF_FFFF);
        rd(REG_ALM_HI, d); eq("R3", "alarm idle high", 64'(d), 64'hFFFF_FFFF);
        rd(REG_EVENT, d);  eq("R3", "alarm and ch0 events", 64'(d), 64'h0001_0080);
        wait_rises(0, 2);
        eq("R5", "period ns", rise_t[0] - prev_rt[0], 64'd1000);
        eq("R5", "period clocks", rise_c[0] - prev_rc[0], 64'd125);
        eq("R6", "width clocks", 64'(last_w[0]), 64'(exp_len(3, 2)));

        // R12 masking
        eq("R12", "irq masked", 64'(irq), 64'd0);
        wr(REG_MASK, 32'h80);
        eq("R12", "irq unmasked", 64'(irq), 64'd1);
        wr(REG_MASK, 32'h0);
        eq("R12", "irq masked again", 64'(irq), 64'd0);
        wr(REG_EVENT, 32'h0001_0080);
        rd(REG_EVENT, d); eq("R11", "write-one clear", 64'(d), 64'd0);

        // R11 clear coinciding with a pulse start
        wait_rises(0, 1);
        repeat (124) @(negedge clk);
        wr(REG_EVENT, 32'h80);
        eq("R11", "collision rise spacing", rise_c[0] - prev_rc[0], 64'd125);
        rd(REG_EVENT, d); eq("R11", "set wins over clear", 64'(d[7]), 64'd1);
        wr(REG_EVENT, 32'h80);
        rd(REG_EVENT, d); eq("R11", "clear away from start", 64'(d[7]), 64'd0);

        // R7/R8 channel 1 inverted and disabled
        set_ctrl(1, ctrl_byte(1, 1, 0, 3));
        eq("R7", "inverted idle level", 64'(pulse_out[1]), 64'd1);
        set_alarm(now_ns + 64'd400);
        lows = 0;
        repeat (200) begin
            @(negedge clk);
            if (!pulse_out[1]) lows++;
        end
        eq("R8", "disabled ignores alarm", 64'(lows), 64'd0);
        rd(REG_EVENT, d); eq("R8", "no ch1 event", 64'(d[6]), 64'd0);
        set_ctrl(1, ctrl_byte(0, 1, 0, 3));
        lows = 0;
        repeat (200) begin
            @(negedge clk);
            if (!pulse_out[1]) lows++;
        end
        eq("R8", "re-enabled waits for alarm", 64'(lows), 64'd0);
        alm = now_ns + 64'd200;
        set_alarm(alm);
        lows = 0;
        while (pulse_out[1] && lows < 100) begin
            @(negedge clk);
            lows++;
        end
        eq("R7", "inverted pulse on alarm", now_ns, alm + 64'd8);

        // R9 free start on channel 2
        wr(REG_IVL0 + 2, 32'd312);
        set_ctrl(2, ctrl_byte(0, 0, 1, 2));
        eq("R9", "not yet active", 64'(pulse_out[2]), 64'd0);
        @(negedge clk);
        eq("R9", "active one cycle later", 64'(pulse_out[2]), 64'd1);

        // R10 time step leaves phase; realign via disable + alarm
        wait_rises(0, 1);
        pr = rise_t[0];
        x = now_ns + 64'd16 + 64'd24;
        set_time(x);
        wait_rises(0, 1);
        eq("R10", "step keeps clock phase", rise_c[0] - prev_rc[0], 64'd125);
        eq("R10", "step shifts time stamp", rise_t[0], pr + 64'd1024);
        set_ctrl(0, ctrl_byte(1, 0, 0, 3));
        set_ctrl(0, ctrl_byte(0, 0, 0, 3));
        alm = ((now_ns + 64'd1000) / 64'd1000 + 64'd1) * 64'd1000;
        set_alarm(alm);
        wait_rises(0, 1);
        eq("R10", "realigned rise", rise_t[0], alm + 64'd8);
        wait_rises(0, 1);
        eq("R10", "aligned after realign", (rise_t[0] - 64'd8) % 64'd1000, 64'd0);

        // random configurations on channel 2 (R5, R6)
        for (int it = 0; it < 6; it++) begin
            int p, w, len, k;
            p   = 1 + int'($urandom % 3);
            w   = int'($urandom % 32);
            len = exp_len(w, p);
            k   = len + 4 + int'($urandom % 40);
            set_ctrl(2, ctrl_byte(1, 0, 0, 0));
            wr(REG_PRESC, 32'(p));
            wr(REG_IVL0 + 2, 32'(8 * k - 8));
            set_ctrl(2, ctrl_byte(0, 0, 1, w));
            wait_rises(2, 3);
            eq("R5", "random period clocks", rise_c[2] - prev_rc[2], 64'(k));
            eq("R5", "random period ns", rise_t[2] - prev_rt[2], 64'(8 * k));
            eq("R6", "random width", 64'(last_w[2]), 64'(len));
        end

        report();
    end

endmodule